// File: doc/BRIEF.md
# Edge-Selectable GPIO Controller

This peripheral manages sixteen general-purpose lines behind a small memory-mapped register port. Each line is either an input or an output. Output lines drive a stored value and raise their output enable. Input lines are sampled through a two-stage synchronizer. On each input line, either a rising or a falling transition can be chosen to raise an event.

Events on input lines that are not masked are held in a status register. Software clears this register by writing ones to it. A single level interrupt stays high while any status bit is set. Software sets up direction, output value, edge polarity and mask, then services the interrupt by reading the status register and clearing it.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the input and status registers read 0x0000. The output, direction, edge and mask registers read 0xFFFF. irq_o is 0, pin_oe_o is 0x0000 and pin_o is 0x0000.
- R2: The byte offsets are 0x00 input, 0x04 output, 0x08 direction, 0x0C edge, 0x10 mask and 0x14 status. A read with rd_en_i high loads rdata_o at that clock edge. rdata_o holds its value until the next read. A written value reads back unchanged from the output, direction, edge and mask registers.
- R3: The input register is read-only. A write to offset 0x00 leaves the output, direction, edge and mask registers unchanged.
- R4: Direction bit 1 makes a line an input and bit 0 makes it an output. For each line i, pin_oe_o[i] is the inverse of direction[i]. pin_o[i] equals output[i] when the line is an output, and is 0 otherwise.
- R5: The output register keeps all 16 written bits whatever the direction. A line switched to output drives its stored bit from the edge that writes the direction register.
- R6: Each pin passes through two flops. A pin change made before edge 1 is returned by an input-register read issued at edge 3, and not by reads issued at edges 1 or 2.
- R7: Edge bit 1 selects a low-to-high transition and bit 0 selects a high-to-low transition. A qualifying pin change made before edge 1 sets its status bit at edge 3.
- R8: An event sets its status bit only when the line's direction bit is 1 and its mask bit is 0.
- R9: A write to offset 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R10: irq_o is 1 exactly while at least one status bit is set. It rises with the first latched bit and falls when the last bit is cleared.
- R11: If a status clear and a new event on the same bit occur at the same edge, the bit stays set.
- R12: Offsets other than the six listed read as 0x0000. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte offset of the register |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| pin_i | input | 16 | External line levels |
| pin_o | output | 16 | Output values to the pads |
| pin_oe_o | output | 16 | Per-line output enable |
| irq_o | output | 1 | Level interrupt |

## Verification
Two operations can land on the same status bit at the same clock edge: a software clear of that bit and a fresh edge event on that line. The bench triggers this case by first getting line 3's status bit set, returning the pin low, and then raising it again. It then times a write of 0x0008 to the status register so the write lands at the same edge where the synchronized event is latched. The bit must still read as set and irq_o must stay high. A later clear with no event pending must then empty the register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NUM_LINES = 16;

  localparam logic [7:0] OFF_IN   = 8'h00;
  localparam logic [7:0] OFF_OUT  = 8'h04;
  localparam logic [7:0] OFF_DIR  = 8'h08;
  localparam logic [7:0] OFF_EDGE = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;

  typedef enum logic [2:0] {
    SEL_IN,
    SEL_OUT,
    SEL_DIR,
    SEL_EDGE,
    SEL_MASK,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] event_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    // polarity picked per line
    assign event_o[i] = rise_sel_i[i] ? (level_i[i] & ~prev_q[i])
                                      : (~level_i[i] & prev_q[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      in_i,
  input  logic [W-1:0]      event_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      rise_sel_o,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o
);
  reg_sel_e     sel;
  logic [W-1:0] out_q, dir_q, edge_q, mask_q, stat_q, rdata_q;
  logic [W-1:0] armed, clr, rd_mux;

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_IN):   sel = SEL_IN;
      ADDR_W'(OFF_OUT):  sel = SEL_OUT;
      ADDR_W'(OFF_DIR):  sel = SEL_DIR;
      ADDR_W'(OFF_EDGE): sel = SEL_EDGE;
      ADDR_W'(OFF_MASK): sel = SEL_MASK;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      default:           sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '1;
      dir_q  <= '1;
      edge_q <= '1;
      mask_q <= '1;
    end else if (wr_en_i) begin
      case (sel)
        SEL_OUT:  out_q  <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_EDGE: edge_q <= wdata_i;
        SEL_MASK: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // only unmasked input lines may latch
  assign armed = event_i & dir_q & ~mask_q;
  assign clr   = (wr_en_i && sel == SEL_STAT) ? wdata_i : '0;

  for (genvar i = 0; i < W; i++) begin : g_stat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[i] <= 1'b0;
      else if (armed[i]) stat_q[i] <= 1'b1;
      else if (clr[i])   stat_q[i] <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_IN:   rd_mux = in_i;
      SEL_OUT:  rd_mux = out_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_EDGE: rd_mux = edge_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = stat_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign rise_sel_o = edge_q;
  assign pin_oe_o   = ~dir_q;
  assign pin_o      = out_q & ~dir_q;
  assign irq_o      = |stat_q;

  assert_in_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_IN) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(edge_q) && $stable(mask_q)));

  assert_unmapped_wr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_NONE) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(edge_q) && $stable(mask_q)));

  assert_unmapped_rd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_NONE) |=> (rdata_o == '0));

  assert_oe_from_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_DIR) |=> (pin_oe_o == ~$past(wdata_i)));

  assert_set_needs_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~($past(dir_q) & ~$past(mask_q))) == '0));

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_STAT) |=> ((stat_q & $past(wdata_i & ~event_i)) == '0));

  assert_event_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed != '0) |=> ((stat_q & $past(armed)) == $past(armed)));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned W      = NUM_LINES,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o
);
  logic [W-1:0] pin_sync, evt, rise_sel;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_edge_det #(.W(W)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (pin_sync),
    .rise_sel_i (rise_sel),
    .event_o    (evt)
  );

  gpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .wdata_i    (wdata_i),
    .in_i       (pin_sync),
    .event_i    (evt),
    .rdata_o    (rdata_o),
    .rise_sel_o (rise_sel),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr;
  logic        wr_en, rd_en;
  logic [15:0] wdata, rdata, pins, pin_out, pin_oe;
  logic        irq;
  int          n_vec = 0;
  int          n_bad = 0;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  gpio_ctrl uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_en),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_i    (pins),
    .pin_o    (pin_out),
    .pin_oe_o (pin_oe),
    .irq_o    (irq)
  );

  // {offset, write data, expected readback}
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {5'h04, 16'h1234, 16'h1234},
    {5'h0C, 16'h0F0F, 16'h0F0F},
    {5'h10, 16'h5555, 16'h5555},
    {5'h08, 16'hA5A5, 16'hA5A5},
    {5'h18, 16'hBEEF, 16'h0000},
    {5'h1C, 16'hFFFF, 16'h0000},
    {5'h00, 16'hFFFF, 16'h0000},
    {5'h14, 16'hFFFF, 16'h0000},
    {5'h08, 16'hFFFF, 16'hFFFF},
    {5'h10, 16'hFFFF, 16'hFFFF}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_lat();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 pin_o", pin_out, 16'h0000);
    bus_read(5'h00, rd); chk("R1 in", rd, 16'h0000);
    bus_read(5'h04, rd); chk("R1 out", rd, 16'hFFFF);
    bus_read(5'h08, rd); chk("R1 dir", rd, 16'hFFFF);
    bus_read(5'h0C, rd); chk("R1 edge", rd, 16'hFFFF);
    bus_read(5'h10, rd); chk("R1 mask", rd, 16'hFFFF);
    bus_read(5'h14, rd); chk("R1 stat", rd, 16'h0000);

    // R2 / R12 table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][36:32], VEC[i][31:16]);
      bus_read(VEC[i][36:32], rd);
      chk($sformatf("R2 vec%0d off=%h", i, VEC[i][36:32]), rd, VEC[i][15:0]);
    end

    // R12 unmapped write leaves mask alone
    bus_write(5'h18, 16'h0000);
    bus_read(5'h10, rd); chk("R12 mask after unmapped wr", rd, 16'hFFFF);
    bus_write(5'h01, 16'h0000);
    bus_read(5'h01, rd); chk("R12 odd offset read", rd, 16'h0000);

    // R3 write to input offset
    bus_write(5'h00, 16'h0000);
    bus_read(5'h08, rd); chk("R3 dir kept", rd, 16'hFFFF);
    bus_read(5'h04, rd); chk("R3 out kept", rd, 16'h1234);

    // R4 pin drive
    bus_write(5'h04, 16'h00F0);
    bus_write(5'h08, 16'hFF00);
    chk("R4 oe", pin_oe, 16'h00FF);
    chk("R4 pin_o", pin_out, 16'h00F0);

    // R5 stored while input, driven on turn-around
    bus_write(5'h08, 16'hFFFF);
    bus_write(5'h04, 16'h8001);
    chk("R5 pin_o as input", pin_out, 16'h0000);
    bus_write(5'h08, 16'h7FFE);
    chk("R5 oe", pin_oe, 16'h8001);
    chk("R5 pin_o driven", pin_out, 16'h8001);
    bus_write(5'h08, 16'hFFFF);

    // R6 two-flop latency
    pins = 16'h0010;
    bus_read(5'h00, rd); chk("R6 edge1 old", rd, 16'h0000);
    bus_read(5'h00, rd); chk("R6 edge2 old", rd, 16'h0000);
    bus_read(5'h00, rd); chk("R6 edge3 new", rd, 16'h0010);
    pins = 16'h0000;
    wait_lat();

    // R7 polarity: lines 0..7 rising, 8..15 falling
    bus_write(5'h0C, 16'h00FF);
    bus_write(5'h10, 16'h0000);
    bus_read(5'h14, rd); chk("R7 stat clean", rd, 16'h0000);
    pins = 16'h0001;
    wait_lat();
    chk("R10 irq raised", {15'd0, irq}, 16'h0001);
    bus_read(5'h14, rd); chk("R7 rise line0", rd, 16'h0001);
    pins = 16'h0101;
    wait_lat();
    bus_read(5'h14, rd); chk("R7 rise on fall-sel ignored", rd, 16'h0001);
    pins = 16'h0001;
    wait_lat();
    bus_read(5'h14, rd); chk("R7 fall line8", rd, 16'h0101);

    // R9 / R10 clear by ones
    bus_write(5'h14, 16'h0001);
    bus_read(5'h14, rd); chk("R9 partial clear", rd, 16'h0100);
    chk("R10 irq still high", {15'd0, irq}, 16'h0001);
    bus_write(5'h14, 16'h0100);
    bus_read(5'h14, rd); chk("R9 full clear", rd, 16'h0000);
    chk("R10 irq dropped", {15'd0, irq}, 16'h0000);

    // R8 mask and direction gate events
    bus_write(5'h10, 16'h0002);
    pins = 16'h0003;
    wait_lat();
    bus_read(5'h14, rd); chk("R8 masked line1", rd, 16'h0000);
    bus_write(5'h08, 16'hFFFB);
    pins = 16'h0007;
    wait_lat();
    bus_read(5'h14, rd); chk("R8 output line2", rd, 16'h0000);
    chk("R8 irq low", {15'd0, irq}, 16'h0000);

    // R11 clear and event on line 3 at the same edge
    pins = 16'h000F;
    wait_lat();
    bus_read(5'h14, rd); chk("R11 setup set", rd, 16'h0008);
    pins = 16'h0007;
    wait_lat();
    bus_read(5'h14, rd); chk("R11 setup fall ignored", rd, 16'h0008);
    pins = 16'h000F;
    @(negedge clk);
    @(negedge clk);
    bus_write(5'h14, 16'h0008);
    chk("R11 irq kept", {15'd0, irq}, 16'h0001);
    bus_read(5'h14, rd); chk("R11 event wins", rd, 16'h0008);
    bus_write(5'h14, 16'h0008);
    bus_read(5'h14, rd); chk("R11 later clear", rd, 16'h0000);
    chk("R10 irq final", {15'd0, irq}, 16'h0000);

    finish_run();
  end
endmodule